// File: doc/BRIEF.md
# One-Wire Bus Bit-Slot Master

This block is the timing engine on the master side of a serial bus that has one open-drain, pulled-up wire. It takes one command at a time on a start/busy/done handshake. There are four commands: send a one, send a zero, read one bit, and issue a reset followed by a presence check. For each command it pulls the wire low or lets it go at the moments the bus timing requires. It samples the wire through a synchronizer and reports a data bit or a reset status when `done` pulses. All slot durations are microsecond parameters. They are counted with a tick enable that is divided from the system clock and restarts at the start of every command, so every slot is exact to the clock cycle.

A read slot does not sample at one fixed point. After the master lets go of the wire, the block polls it. The bit is 1 when the wire is seen high early enough and 0 when it rises late or not at all. A reset checks the released wire before it drives the bus and checks it again at the end of the reset window. A low wire at either point is reported as a wiring fault. Byte assembly, addressing, bus search, CRC and strong pull-up power are left to other logic.

Top module: `ow_slot_master`

## Requirements
- R1: After reset the outputs are `busy`=0, `done`=0, `bus_pull_low`=0, `bus_release`=1, `status`=00 and `rd_bit`=0.
- R2: A write-one command (`cmd`=01) pulls the wire low for T_LOW1_US microseconds from the accepting clock edge. `done` pulses (T_SLOT_US+T_REC_US) microseconds after that edge, with `status`=00 and `rd_bit`=0.
- R3: A write-zero command (`cmd`=00) pulls the wire low for T_LOW0_US microseconds. `done` pulses (T_SLOT_US+T_REC_US) microseconds after the accepting edge, with `status`=00.
- R4: A read command (`cmd`=10) pulls the wire low for T_LOWR_US microseconds and then releases it. `rd_bit` is 1 when the synchronized wire is seen high while fewer than T_RDV_US whole microseconds have passed since the accepting edge.
- R5: A read returns `rd_bit`=0 when the wire first reads high at or after T_RDV_US microseconds, or never reads high. Polling gives up at T_RDV_US+2 microseconds.
- R6: A read slot always ends with `done` (T_SLOT_US+T_REC_US) microseconds after the accepting edge, with `status`=00, whatever the wire does.
- R7: A reset command (`cmd`=11) that finds the synchronized wire low when it is accepted never pulls the wire. It pulses `done` on the next cycle with `status`=11 (fault).
- R8: A reset pulls the wire low for T_RSTL_US microseconds. It samples the wire T_PDH_US+T_PDL_US/2 microseconds after the release: low gives `status`=01 (presence), high gives `status`=10 (no presence).
- R9: A reset finishes (T_RSTL_US+T_RSTH_US) microseconds after the accepting edge. If the wire is still low then, `status`=11 (fault) overrides the presence result.
- R10: A `start` pulse while `busy`=1 is ignored. The running command ends at its own time with its own result, and no extra `done` follows.
- R11: `done` is a one-cycle pulse with `busy`=0 in the same cycle. `busy`=1 from the cycle after acceptance until `done`. `status` and `rd_bit` change only together with `done` and hold their values between commands.
- R12: `bus_release` is always the complement of `bus_pull_low`, and the wire is never pulled while `busy`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, accepted when idle |
| cmd | input | 2 | 00 write zero, 01 write one, 10 read, 11 reset/presence |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 slot ok, 01 presence, 10 no presence, 11 wiring fault |
| rd_bit | output | 1 | Bit from the last command (0 for non-read commands) |
| bus_pull_low | output | 1 | Enable for the open-drain pull-down |
| bus_release | output | 1 | High while the wire is left to the pull-up |
| line_in | input | 1 | Raw wire level, synchronized inside |

## Verification
Every result falls a known number of whole microsecond ticks after the accepting edge. Slot completion comes (T_SLOT_US+T_REC_US)·CLK_PER_US cycles after it and reset completion (T_RSTL_US+T_RSTH_US)·CLK_PER_US cycles after it. A fault found before a reset is due on the very next edge. The bench counts falling edges from the edge that accepts `start` and requires `done` at exactly that count plus one. Over the same span it counts pull-low cycles and compares them with the low time. The responding device is modeled on the wire so that it changes level at chosen cycle offsets. The read boundary is placed so that the two synchronizer stages put the decision either one cycle before or exactly at the T_RDV_US microsecond. Presence and stuck-wire windows cover their sampling edges by at least a microsecond.

// File: rtl/ow_pkg.sv
package ow_pkg;

    typedef enum logic [1:0] {
        OW_CMD_W0  = 2'b00,
        OW_CMD_W1  = 2'b01,
        OW_CMD_RD  = 2'b10,
        OW_CMD_RST = 2'b11
    } ow_cmd_e;

    typedef enum logic [1:0] {
        OW_ST_OK      = 2'b00,
        OW_ST_PRESENT = 2'b01,
        OW_ST_ABSENT  = 2'b10,
        OW_ST_FAULT   = 2'b11
    } ow_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOW,
        S_POLL,
        S_HOLD,
        S_RST_LOW,
        S_RST_WAIT,
        S_RST_TAIL
    } ow_state_e;

    typedef struct packed {
        ow_status_e status;
        logic       bit_val;
    } ow_result_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int width_of(input int v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction

endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '1;
                else     sh_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '1;
                else     sh_q <= {sh_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/ow_us_timer.sv
module ow_us_timer #(
    parameter int CLK_PER_US = 125,
    parameter int EL_W       = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    output logic            tick,
    output logic [EL_W-1:0] el_us
);
    localparam int DIV_W = ow_pkg::width_of(CLK_PER_US);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);

    logic [DIV_W-1:0] div_q;
    logic [EL_W-1:0]  el_q;

    assign tick  = (div_q == DIV_LAST) && !restart;
    assign el_us = el_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            div_q <= '0;
            el_q  <= '0;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
            el_q  <= el_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/ow_slot_fsm.sv
module ow_slot_fsm
    import ow_pkg::*;
#(
    parameter int EL_W      = 10,
    parameter int T_SLOT_US = 60,
    parameter int T_REC_US  = 2,
    parameter int T_LOW1_US = 6,
    parameter int T_LOW0_US = 60,
    parameter int T_LOWR_US = 5,
    parameter int T_RDV_US  = 15,
    parameter int T_RSTL_US = 480,
    parameter int T_RSTH_US = 480,
    parameter int T_PDH_US  = 15,
    parameter int T_PDL_US  = 60
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  ow_cmd_e         cmd,
    input  logic            tick,
    input  logic [EL_W-1:0] el_us,
    input  logic            line_s,
    output logic            restart,
    output logic            pull_low,
    output logic            busy,
    output logic            done,
    output ow_result_t      result
);
    localparam logic [EL_W-1:0] LOW1_LAST = EL_W'(T_LOW1_US - 1);
    localparam logic [EL_W-1:0] LOW0_LAST = EL_W'(T_LOW0_US - 1);
    localparam logic [EL_W-1:0] LOWR_LAST = EL_W'(T_LOWR_US - 1);
    localparam logic [EL_W-1:0] RDV_V     = EL_W'(T_RDV_US);
    localparam logic [EL_W-1:0] POLL_LAST = EL_W'(T_RDV_US + 1);
    localparam logic [EL_W-1:0] SLOT_LAST = EL_W'(T_SLOT_US + T_REC_US - 1);
    localparam logic [EL_W-1:0] RSTL_LAST = EL_W'(T_RSTL_US - 1);
    localparam logic [EL_W-1:0] PRES_LAST = EL_W'(T_RSTL_US + T_PDH_US + T_PDL_US / 2 - 1);
    localparam logic [EL_W-1:0] RST_LAST  = EL_W'(T_RSTL_US + T_RSTH_US - 1);

    ow_state_e       state_q;
    logic [EL_W-1:0] low_last_q;
    logic            is_read_q;
    logic            bit_q;
    logic            pres_q;
    logic            done_q;
    ow_result_t      res_q;

    assign restart  = start && (state_q == S_IDLE);
    assign pull_low = (state_q == S_LOW) || (state_q == S_RST_LOW);
    assign busy     = (state_q != S_IDLE);
    assign done     = done_q;
    assign result   = res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= S_IDLE;
            low_last_q <= '0;
            is_read_q  <= 1'b0;
            bit_q      <= 1'b0;
            pres_q     <= 1'b0;
            done_q     <= 1'b0;
            res_q      <= '{status: OW_ST_OK, bit_val: 1'b0};
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        bit_q     <= 1'b0;
                        is_read_q <= (cmd == OW_CMD_RD);
                        unique case (cmd)
                            OW_CMD_W0: begin
                                low_last_q <= LOW0_LAST;
                                state_q    <= S_LOW;
                            end
                            OW_CMD_W1: begin
                                low_last_q <= LOW1_LAST;
                                state_q    <= S_LOW;
                            end
                            OW_CMD_RD: begin
                                low_last_q <= LOWR_LAST;
                                state_q    <= S_LOW;
                            end
                            OW_CMD_RST: begin
                                if (!line_s) begin
                                    done_q <= 1'b1;
                                    res_q  <= '{status: OW_ST_FAULT, bit_val: 1'b0};
                                end else begin
                                    state_q <= S_RST_LOW;
                                end
                            end
                        endcase
                    end
                end
                S_LOW: begin
                    if (tick && el_us == low_last_q)
                        state_q <= is_read_q ? S_POLL : S_HOLD;
                end
                S_POLL: begin
                    if (line_s) begin
                        bit_q   <= (el_us < RDV_V);
                        state_q <= S_HOLD;
                    end else if (tick && el_us == POLL_LAST) begin
                        bit_q   <= 1'b0;
                        state_q <= S_HOLD;
                    end
                end
                S_HOLD: begin
                    if (tick && el_us == SLOT_LAST) begin
                        done_q  <= 1'b1;
                        res_q   <= '{status: OW_ST_OK, bit_val: bit_q};
                        state_q <= S_IDLE;
                    end
                end
                S_RST_LOW: begin
                    if (tick && el_us == RSTL_LAST)
                        state_q <= S_RST_WAIT;
                end
                S_RST_WAIT: begin
                    if (tick && el_us == PRES_LAST) begin
                        pres_q  <= !line_s;
                        state_q <= S_RST_TAIL;
                    end
                end
                S_RST_TAIL: begin
                    if (tick && el_us == RST_LAST) begin
                        done_q <= 1'b1;
                        if (!line_s)
                            res_q <= '{status: OW_ST_FAULT, bit_val: 1'b0};
                        else if (pres_q)
                            res_q <= '{status: OW_ST_PRESENT, bit_val: 1'b0};
                        else
                            res_q <= '{status: OW_ST_ABSENT, bit_val: 1'b0};
                        state_q <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ow_slot_master.sv
module ow_slot_master #(
    parameter int CLK_PER_US  = 125,
    parameter int SYNC_STAGES = 2,
    parameter int T_SLOT_US   = 60,
    parameter int T_REC_US    = 2,
    parameter int T_LOW1_US   = 6,
    parameter int T_LOW0_US   = 60,
    parameter int T_LOWR_US   = 5,
    parameter int T_RDV_US    = 15,
    parameter int T_RSTL_US   = 480,
    parameter int T_RSTH_US   = 480,
    parameter int T_PDH_US    = 15,
    parameter int T_PDL_US    = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] cmd,
    output logic       busy,
    output logic       done,
    output logic [1:0] status,
    output logic       rd_bit,
    output logic       bus_pull_low,
    output logic       bus_release,
    input  logic       line_in
);
    localparam int MAX_US = ow_pkg::max3(T_SLOT_US + T_REC_US,
                                         T_RSTL_US + T_RSTH_US,
                                         T_RDV_US + 2);
    localparam int EL_W   = ow_pkg::width_of(MAX_US + 1);

    logic             line_s;
    logic             restart;
    logic             tick;
    logic [EL_W-1:0]  el_us;
    logic             pull_low;
    ow_pkg::ow_result_t result;

    ow_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (line_in),
        .dout (line_s)
    );

    ow_us_timer #(.CLK_PER_US(CLK_PER_US), .EL_W(EL_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick),
        .el_us   (el_us)
    );

    ow_slot_fsm #(
        .EL_W      (EL_W),
        .T_SLOT_US (T_SLOT_US),
        .T_REC_US  (T_REC_US),
        .T_LOW1_US (T_LOW1_US),
        .T_LOW0_US (T_LOW0_US),
        .T_LOWR_US (T_LOWR_US),
        .T_RDV_US  (T_RDV_US),
        .T_RSTL_US (T_RSTL_US),
        .T_RSTH_US (T_RSTH_US),
        .T_PDH_US  (T_PDH_US),
        .T_PDL_US  (T_PDL_US)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd      (ow_pkg::ow_cmd_e'(cmd)),
        .tick     (tick),
        .el_us    (el_us),
        .line_s   (line_s),
        .restart  (restart),
        .pull_low (pull_low),
        .busy     (busy),
        .done     (done),
        .result   (result)
    );

    assign status       = result.status;
    assign rd_bit       = result.bit_val;
    assign bus_pull_low = pull_low;
    assign bus_release  = !pull_low;
endmodule

// File: rtl/ow_slot_master_chk.sv
module ow_slot_master_chk #(
    parameter int PER        = 125,
    parameter int MAX_LOW_US = 480
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [1:0] status,
    input logic       rd_bit,
    input logic       bus_pull_low
);
    localparam int LOW_LIM = PER * MAX_LOW_US;

    int low_run;

    always_ff @(posedge clk) begin
        if (rst)               low_run <= 0;
        else if (bus_pull_low) low_run <= low_run + 1;
        else                   low_run <= 0;
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({status, rd_bit}) |-> done);

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) || $past(start)));

    // R12
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_pull_low);

    // R3
    low_len_chk: assert property (@(posedge clk) disable iff (rst)
        bus_pull_low |-> (low_run < LOW_LIM));
endmodule

bind ow_slot_master ow_slot_master_chk #(
    .PER        (CLK_PER_US),
    .MAX_LOW_US (ow_pkg::max3(T_RSTL_US, T_LOW0_US, T_LOW1_US))
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .status       (status),
    .rd_bit       (rd_bit),
    .bus_pull_low (bus_pull_low)
);

// File: tb/ow_slot_master_bench.sv
module ow_slot_master_bench;
    localparam int P     = 4;
    localparam int SLOT  = 60;
    localparam int REC   = 2;
    localparam int LOW1  = 6;
    localparam int LOW0  = 60;
    localparam int LOWR  = 5;
    localparam int RDV   = 15;
    localparam int RSTL  = 480;
    localparam int RSTH  = 480;
    localparam int PDH   = 15;
    localparam int PDL   = 60;
    localparam int SLOT_T = SLOT + REC;
    localparam int RST_T  = RSTL + RSTH;
    localparam int PW0    = (RSTL + PDH) * P;
    localparam int NV     = 10;

    // table: command, wire-low window [from,to) in cycles, expected status,
    // expected bit, expected low microseconds, expected total microseconds
    localparam int V_CMD[NV]  = '{1, 0, 2, 2, 2, 2, 2, 3, 3, 3};
    localparam int V_FROM[NV] = '{-1, -1, 1, 1, 1, 1, 1, PW0, -1, PW0};
    localparam int V_TO[NV]   = '{-1, -1, 8*P, RDV*P-3, RDV*P-1, (RDV+1)*P,
                                  (SLOT_T+5)*P, PW0+PDL*P, -1, (RST_T+5)*P};
    localparam int V_ST[NV]   = '{0, 0, 0, 0, 0, 0, 0, 1, 2, 3};
    localparam int V_BIT[NV]  = '{0, 0, 1, 1, 0, 0, 0, 0, 0, 0};
    localparam int V_LOW[NV]  = '{LOW1, LOW0, LOWR, LOWR, LOWR, LOWR, LOWR,
                                  RSTL, RSTL, RSTL};
    localparam int V_TOT[NV]  = '{SLOT_T, SLOT_T, SLOT_T, SLOT_T, SLOT_T,
                                  SLOT_T, SLOT_T, RST_T, RST_T, RST_T};
    localparam string V_REQ[NV] = '{"R2", "R3", "R4", "R4", "R5", "R5", "R6",
                                    "R8", "R8", "R9"};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic       busy, done, rd_bit, bus_pull_low, bus_release;
    logic [1:0] status;
    logic       slave_low = 1'b0;
    logic       line_in;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    assign line_in = ~(bus_pull_low | slave_low);

    always #4 clk = ~clk;

    ow_slot_master #(
        .CLK_PER_US(P), .T_SLOT_US(SLOT), .T_REC_US(REC), .T_LOW1_US(LOW1),
        .T_LOW0_US(LOW0), .T_LOWR_US(LOWR), .T_RDV_US(RDV), .T_RSTL_US(RSTL),
        .T_RSTH_US(RSTH), .T_PDH_US(PDH), .T_PDL_US(PDL)
    ) u_ow_slot_master (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd), .busy(busy),
        .done(done), .status(status), .rd_bit(rd_bit),
        .bus_pull_low(bus_pull_low), .bus_release(bus_release),
        .line_in(line_in)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Issues one command; counts falling edges to done, pull-low cycles and
    // pair mismatches; optionally pokes a second start at cycle poke_at.
    task automatic run_cmd(input int c, input int from_c, input int to_c,
                           input bit stuck, input int poke_at,
                           output int tot, output int lowc, output int mism,
                           output bit busy_first);
        @(negedge clk);
        cmd = 2'(c);
        start = 1'b1;
        tot = 0; lowc = 0; mism = 0; busy_first = 0;
        forever begin
            @(negedge clk);
            tot++;
            start = 1'b0;
            if (tot == 1) busy_first = busy;
            if (tot == poke_at) begin
                start = 1'b1;
                cmd = 2'b11;
            end
            if (bus_pull_low) lowc++;
            if (bus_release == bus_pull_low) mism++;
            slave_low = stuck || (tot >= from_c && tot < to_c);
            if (done) break;
            if (tot > 20000) begin
                chk(0, "R11", "timeout waiting for done", tot, 0);
                break;
            end
        end
        slave_low = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int tot, lowc, mism, ndone;
        bit bf;

        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
        chk(!bus_pull_low && bus_release, "R1", "wire pair after reset",
            {bus_pull_low, bus_release}, 1);
        chk(status == 2'b00 && rd_bit == 1'b0, "R1", "result after reset",
            {status, rd_bit}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_cmd(V_CMD[i], V_FROM[i], V_TO[i], 1'b0, -1, tot, lowc, mism, bf);
            chk(tot == V_TOT[i] * P + 1, V_REQ[i], $sformatf("row %0d done cycle", i),
                tot, V_TOT[i] * P + 1);
            chk(lowc == V_LOW[i] * P, V_REQ[i], $sformatf("row %0d low cycles", i),
                lowc, V_LOW[i] * P);
            chk(status == 2'(V_ST[i]), V_REQ[i], $sformatf("row %0d status", i),
                status, V_ST[i]);
            chk(rd_bit == 1'(V_BIT[i]), V_REQ[i], $sformatf("row %0d bit", i),
                rd_bit, V_BIT[i]);
            chk(!busy && bf, "R11", $sformatf("row %0d busy framing", i),
                {bf, busy}, 2);
            chk(mism == 0, "R12", $sformatf("row %0d pair mismatches", i), mism, 0);
            repeat (3) @(negedge clk);
        end

        // R11: result holds between commands
        run_cmd(2, 1, 8 * P, 1'b0, -1, tot, lowc, mism, bf);
        repeat (40) @(negedge clk);
        chk(rd_bit == 1'b1 && status == 2'b00 && !done, "R11", "held read result",
            {status, rd_bit, done}, 1);

        // R7: stuck wire before reset
        slave_low = 1'b1;
        repeat (4) @(negedge clk);
        run_cmd(3, -1, -1, 1'b1, -1, tot, lowc, mism, bf);
        chk(tot == 1, "R7", "fault done cycle", tot, 1);
        chk(status == 2'b11, "R7", "fault status", status, 3);
        chk(lowc == 0, "R7", "pull cycles while faulted", lowc, 0);
        repeat (4) @(negedge clk);

        // R10: start while busy ignored
        run_cmd(1, -1, -1, 1'b0, 10, tot, lowc, mism, bf);
        chk(tot == SLOT_T * P + 1, "R10", "done cycle with poke", tot, SLOT_T * P + 1);
        chk(status == 2'b00 && rd_bit == 1'b0, "R10", "write result kept",
            {status, rd_bit}, 0);
        chk(lowc == LOW1 * P, "R10", "low cycles with poke", lowc, LOW1 * P);
        ndone = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (done || busy || bus_pull_low) ndone++;
        end
        chk(ndone == 0, "R10", "activity after ignored start", ndone, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule